// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static memory. Reads and writes can be issued in any order on consecutive clocks, and the data bus carries a word on every clock. Write data trails its address by the same two enabled edges as read data. A read followed by a write therefore never needs an idle bus cycle.

Each operation is issued on a rising edge. The load/advance input either starts a new access at an external address or steps a four-beat burst. Each beat of a burst repeats the operation that was last loaded. An active-low clock enable freezes the whole pipeline, and three synchronous selects qualify each new access. The data bus is brought out as separate input, output and drive-enable ports, so a pad ring can build the shared tristate bus. An asynchronous output enable gates the drive-enable. The array depth is a parameter, so a small memory can be simulated.

Top module: `pipe_sram`

## Requirements
- R1: When `rst_n` is low, or after it, `dq_oe` is 0 until a read is issued. The pipeline starts empty. Advance cycles issued straight after reset perform no access.
- R2: A selected load with `wr_n`=1 at enabled edge E puts the addressed word on `dq_o` with `dq_oe`=1 after edge E+1, to be sampled at edge E+2. The word stays there until the next enabled edge.
- R3: A selected load with `wr_n`=0 at edge E takes its data from `dq_i` at enabled edge E+2. `dq_oe` is 0 during the cycle before that edge.
- R4: The word has four 9-bit lanes, with lane k at bits [9k+8:9k]. A low `bw_n[k]` writes lane k, and the other lanes keep their old contents. `bw_n` is sampled with the address on each beat.
- R5: A load is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other load is a deselect. It drives nothing and leaves the array unchanged.
- R6: An edge with `clk_en_n`=1 is ignored. Outputs, pipeline, burst state and array all hold, and `dq_i` is not sampled.
- R7: An edge with `ld_n`=1 issues the next beat of the last loaded operation (read, write or deselect). On such an edge `sel_*`, `wr_n` and `burst_il` are ignored, and address bits above bit 1 stay those of the loaded address.
- R8: With `burst_il`=0 at the load, beat n uses low address bits (start+n) mod 4, so the fifth beat wraps back to the start.
- R9: With `burst_il`=1 at the load, beat n uses low address bits start XOR n. The mode is held from the load for the whole burst.
- R10: A read issued one enabled edge after a write to the same address returns the written lanes merged over the old word.
- R11: `oe_n`=1 forces `dq_oe` to 0 at once, without clocking, and does not disturb the pipeline.
- R12: Reads and writes alternating every cycle to arbitrary addresses each return the latest data in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Synchronous select, active low |
| sel_b | input | 1 | Synchronous select, active high |
| sel_c_n | input | 1 | Synchronous select, active low |
| ld_n | input | 1 | Low loads a new address, high advances the burst |
| wr_n | input | 1 | Low requests a write on a load |
| burst_il | input | 1 | Burst order on a load: 0 linear, 1 interleaved |
| bw_n | input | 4 | Active-low lane write selects |
| addr | input | log2(DEPTH) | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | 36 | Write data from the bus |
| dq_o | output | 36 | Registered read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench targets the edge where a write commits while a read of the same address is sampled. A design without forwarding would return the stale word there. It sweeps all four burst start offsets in both orders, including the wrap on the fifth beat. A wrong offset rule would return words out of sequence, and taking selects or the write flag on advance beats would corrupt bursts. Random stalls with junk on `dq_i` would expose a pipeline that leaks through a disabled edge or samples write data early. Deselect and output-enable sweeps would catch a design that drives the bus or writes the array when it should not.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits of burst beat n from the starting offset.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       il);
    return il ? (start ^ beat) : 2'(start + beat);
  endfunction

  // Replace the lanes whose active-low select is asserted.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  sel_n);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++) begin
      if (!sel_n[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/sram_cmd.sv
module sram_cmd
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld_n,
  input  logic             wr_n,
  input  logic             sel_ok,
  input  logic             burst_il,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_bw_n
);
  op_e           last_op;
  logic [AW-1:0] base;
  logic [1:0]    beat;
  logic [1:0]    beat_nx;
  logic          il_q;
  op_e           op_new;
  logic          load_evt;
  logic          adv_evt;
  logic [AW-1:0] burst_addr;

  assign load_evt   = en & ~ld_n;
  assign adv_evt    = en & ld_n;
  assign beat_nx    = beat + 2'd1;
  assign burst_addr = {base[AW-1:2], beat_offset(base[1:0], beat_nx, il_q)};

  always_comb begin
    op_new = OP_IDLE;
    if (sel_ok) op_new = wr_n ? OP_RD : OP_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= OP_IDLE;
      base    <= '0;
      beat    <= '0;
      il_q    <= 1'b0;
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_bw_n <= '1;
    end else if (load_evt) begin
      last_op <= op_new;
      base    <= addr;
      beat    <= '0;
      il_q    <= burst_il;
      s1_op   <= op_new;
      s1_addr <= addr;
      s1_bw_n <= bw_n;
    end else if (adv_evt) begin
      beat    <= beat_nx;
      s1_op   <= last_op;
      s1_addr <= burst_addr;
      s1_bw_n <= bw_n;
    end
  end
endmodule

// File: rtl/sram_core.sv
module sram_core
  import pipe_sram_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               s1_op,
  input  logic [AW-1:0]     s1_addr,
  input  logic [LANES-1:0]  s1_bw_n,
  input  logic [WORD_W-1:0] wr_data,
  output logic              s2_wr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     s2_addr;
  logic [LANES-1:0]  s2_bw_n;
  logic              commit;
  logic              fwd_hit;
  logic [WORD_W-1:0] arr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bw_n <= '1;
    end else if (en) begin
      s2_wr   <= (s1_op == OP_WR);
      s2_addr <= s1_addr;
      s2_bw_n <= s1_bw_n;
    end
  end

  assign commit = en & s2_wr;

  always_ff @(posedge clk) begin
    if (commit) mem[s2_addr] <= lane_merge(mem[s2_addr], wr_data, s2_bw_n);
  end

  // A write committing on the same edge as this read is merged in here.
  assign arr_word = mem[s1_addr];
  assign fwd_hit  = s2_wr && (s2_addr == s1_addr);
  assign rd_word  = fwd_hit ? lane_merge(arr_word, wr_data, s2_bw_n) : arr_word;
endmodule

// File: rtl/sram_dq.sv
module sram_dq
  import pipe_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               s1_op,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              oe_n,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              drv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o  <= '0;
      drv_q <= 1'b0;
    end else if (en) begin
      dq_o  <= rd_word;
      drv_q <= (s1_op == OP_RD);
    end
  end

  assign dq_oe = drv_q & ~oe_n;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              ld_n,
  input  logic              wr_n,
  input  logic              burst_il,
  input  logic [LANES-1:0]  bw_n,
  input  logic [AW-1:0]     addr,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe
);
  logic              en;
  logic              sel_ok;
  op_e               s1_op;
  logic [AW-1:0]     s1_addr;
  logic [LANES-1:0]  s1_bw_n;
  logic              s2_wr;
  logic [WORD_W-1:0] rd_word;
  logic              drv_q;

  assign en     = ~clk_en_n;
  assign sel_ok = ~sel_a_n & sel_b & ~sel_c_n;

  sram_cmd #(.AW(AW)) cmd_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ld_n(ld_n), .wr_n(wr_n),
    .sel_ok(sel_ok), .burst_il(burst_il), .addr(addr), .bw_n(bw_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_bw_n(s1_bw_n)
  );

  sram_core #(.DEPTH(DEPTH), .AW(AW)) core_i (
    .clk(clk), .rst_n(rst_n), .en(en), .s1_op(s1_op), .s1_addr(s1_addr),
    .s1_bw_n(s1_bw_n), .wr_data(dq_i), .s2_wr(s2_wr), .rd_word(rd_word)
  );

  sram_dq dq_i_stage (
    .clk(clk), .rst_n(rst_n), .en(en), .s1_op(s1_op), .rd_word(rd_word),
    .oe_n(oe_n), .dq_o(dq_o), .dq_oe(dq_oe), .drv_q(drv_q)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              ld_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [WORD_W-1:0] dq_o,
  input op_e               s1_op,
  input logic [AW-1:0]     s1_addr,
  input logic              s2_wr,
  input logic              drv_q
);
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s1_op == OP_RD) |=> (dq_oe || oe_n)); // R2

  AST_WRITE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    s2_wr |-> !drv_q); // R3

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_n && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_op == OP_IDLE)); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(drv_q) && $stable(s1_addr) && $stable(s2_wr))); // R6

  AST_STALL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && drv_q) |=> $stable(dq_o)); // R6

  AST_BURST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ld_n) |=> (s1_addr[AW-1:2] == $past(s1_addr[AW-1:2]))); // R7

  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R11
endmodule

bind pipe_sram pipe_sram_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ld_n(ld_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .dq_o(dq_o), .s1_op(s1_op), .s1_addr(s1_addr),
  .s2_wr(s2_wr), .drv_q(drv_q)
);

// File: tb/pipe_sram_tb_top.sv
`timescale 1ns/1ps
module pipe_sram_tb_top;
  localparam int TB_DEPTH = 16;
  localparam int TB_AW    = 4;
  localparam logic [2:0] SEL_ON  = 3'b010;
  localparam logic [2:0] SEL_OFF = 3'b101;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, clk_en_n, sel_a_n, sel_b, sel_c_n, ld_n, wr_n, burst_il, oe_n;
  logic [3:0]  bw_n;
  logic [TB_AW-1:0] addr;
  logic [35:0] dq_i, dq_o;
  logic        dq_oe;

  pipe_sram #(.DEPTH(TB_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .ld_n(ld_n), .wr_n(wr_n),
    .burst_il(burst_il), .bw_n(bw_n), .addr(addr), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [35:0] refm [TB_DEPTH];
  int m1_op = 0, m1_addr = 0, m2_op = 0, m2_addr = 0;
  logic [3:0] m1_bw = 4'hF, m2_bw = 4'hF;
  int b_last = 0, b_base = 0, b_n = 0;
  bit b_il = 1'b0;
  bit exp_drv = 1'b0;
  logic [35:0] exp_q = '0;
  int edge_cnt = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [35:0] wpat(input int e);
    logic [8:0] x;
    x = 9'(e * 53 + 17);
    return {x, ~x, x ^ 9'h0F3, x + 9'd101};
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic chk(input bit ok, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", cur_req, act, exp);
    end
  endtask

  // Reference behaviour of one enabled edge, built from the requirements.
  task automatic model_edge(input bit ld, input bit wr, input logic [2:0] sel,
                            input int a, input logic [3:0] bw, input bit il);
    if (m2_op == 2)
      for (int k = 0; k < 4; k++)
        if (!m2_bw[k]) refm[m2_addr][k*9 +: 9] = dq_i[k*9 +: 9];
    exp_drv = (m1_op == 1);
    if (exp_drv) exp_q = refm[m1_addr];
    m2_op = m1_op; m2_addr = m1_addr; m2_bw = m1_bw;
    if (ld) begin
      m1_op  = (sel == SEL_ON) ? (wr ? 2 : 1) : 0;
      b_last = m1_op; b_base = a; b_n = 0; b_il = il;
      m1_addr = a;
    end else begin
      b_n = (b_n + 1) % 4;
      m1_op = b_last;
      m1_addr = (b_base / 4) * 4 +
                (b_il ? ((b_base % 4) ^ b_n) : ((b_base % 4 + b_n) % 4));
    end
    m1_bw = bw;
    edge_cnt++;
  endtask

  task automatic check_bus();
    if (oe_n) chk(dq_oe === 1'b0, {35'b0, dq_oe}, 36'b0);
    else begin
      chk(dq_oe === exp_drv, {35'b0, dq_oe}, {35'b0, exp_drv});
      if (exp_drv) chk(dq_o === exp_q, dq_o, exp_q);
    end
  endtask

  task automatic cyc(input bit en, input bit ld, input bit wr, input logic [2:0] sel,
                     input int a, input logic [3:0] bw, input bit il);
    clk_en_n = !en; ld_n = !ld; wr_n = !wr;
    {sel_a_n, sel_b, sel_c_n} = sel;
    addr = a[TB_AW-1:0]; bw_n = bw; burst_il = il;
    dq_i = (en && m2_op == 2) ? wpat(edge_cnt) : 36'hA5A5A5A5A;
    @(posedge clk);
    if (en) model_edge(ld, wr, sel, a, bw, il);
    @(negedge clk);
    check_bus();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b0, SEL_OFF, 0, 4'hF, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; {sel_a_n, sel_b, sel_c_n} = SEL_OFF;
    ld_n = 1'b0; wr_n = 1'b1; burst_il = 1'b0; oe_n = 1'b0;
    bw_n = 4'hF; addr = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    chk(dq_oe === 1'b0, {35'b0, dq_oe}, 36'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, SEL_ON, 0, 4'hF, 1'b0);

    cur_req = "R3";
    for (int a = 0; a < TB_DEPTH; a++) cyc(1'b1, 1'b1, 1'b1, SEL_ON, a, 4'h0, 1'b0);
    idle(2);
    cur_req = "R2";
    for (int a = 0; a < TB_DEPTH; a++) cyc(1'b1, 1'b1, 1'b0, SEL_ON, a, 4'hF, 1'b0);
    idle(2);

    cur_req = "R4";
    for (int a = 0; a < TB_DEPTH; a++) cyc(1'b1, 1'b1, 1'b1, SEL_ON, a, 4'(a), 1'b0);
    idle(2);
    for (int a = 0; a < TB_DEPTH; a++) cyc(1'b1, 1'b1, 1'b0, SEL_ON, a, 4'hF, 1'b0);
    idle(2);

    cur_req = "R5";
    for (int s = 0; s < 8; s++) begin
      if (3'(s) != SEL_ON) begin
        cyc(1'b1, 1'b1, 1'b1, 3'(s), 5, 4'h0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 3'(s), 5, 4'hF, 1'b0);
        idle(2);
        cyc(1'b1, 1'b1, 1'b0, SEL_ON, 5, 4'hF, 1'b0);
        idle(2);
      end
    end

    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        cur_req = "R7";
        cyc(1'b1, 1'b1, 1'b1, SEL_ON, 8 + s, 4'h0, il[0]);
        for (int b = 0; b < 3; b++)
          cyc(1'b1, 1'b0, 1'b0, SEL_OFF, 0, 4'(b * 5), !il[0]);
        idle(2);
        cur_req = il[0] ? "R9" : "R8";
        cyc(1'b1, 1'b1, 1'b0, SEL_ON, 8 + s, 4'hF, il[0]);
        for (int b = 0; b < 4; b++)
          cyc(1'b1, 1'b0, 1'b1, SEL_OFF, 3, 4'hF, !il[0]);
        idle(2);
      end
    end

    cur_req = "R10";
    for (int m = 0; m < 16; m++) begin
      cyc(1'b1, 1'b1, 1'b1, SEL_ON, m, 4'(m), 1'b0);
      cyc(1'b1, 1'b1, 1'b0, SEL_ON, m, 4'hF, 1'b0);
      idle(2);
    end

    cur_req = "R11";
    cyc(1'b1, 1'b1, 1'b0, SEL_ON, 3, 4'hF, 1'b0);
    idle(1);
    oe_n = 1'b1; #2;
    chk(dq_oe === 1'b0, {35'b0, dq_oe}, 36'b0);
    oe_n = 1'b0; #2;
    chk(dq_oe === 1'b1, {35'b0, dq_oe}, 36'b1);
    chk(dq_o === exp_q, dq_o, exp_q);
    oe_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, SEL_ON, 3, 4'h0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, SEL_ON, 3, 4'hF, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, SEL_ON, 4, 4'hF, 1'b0);
    oe_n = 1'b0;
    idle(1);
    cyc(1'b1, 1'b1, 1'b0, SEL_ON, 3, 4'hF, 1'b0);
    idle(2);

    cur_req = "R12";
    for (int i = 0; i < 200; i++) begin
      step_lfsr();
      if (i % 2 == 0) cyc(1'b1, 1'b1, 1'b1, SEL_ON, int'(lfsr[3:0]), lfsr[7:4], 1'b0);
      else            cyc(1'b1, 1'b1, 1'b0, SEL_ON, int'(lfsr[11:8]), 4'hF, 1'b0);
    end
    idle(2);

    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      cyc(lfsr[1:0] != 2'b00, lfsr[2] | lfsr[3], lfsr[4],
          (lfsr[6:5] == 2'b00) ? lfsr[9:7] : SEL_ON,
          int'(lfsr[13:10]), lfsr[3:0] ^ lfsr[15:12], lfsr[14]);
    end
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=%0d exp=%0d", 50000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule